// File: doc/BRIEF.md
# Queued-Duty Pulse-Width Modulator

This block generates a single pulse-width modulated output whose on-time comes from a short queue of duty values. Software writes duty samples over a simple register bus. A counter runs from zero up to a programmable terminal value and then returns to zero. At each return to zero, the counter takes the next queued sample. The output is high from count zero until the count reaches the active sample, and low for the rest of the period.

The queue decouples software timing from the waveform. Software can keep several future duty values queued ahead of the counter. A duty value never takes effect partway through a period. This holds even when the queue is empty at the moment of the write: the value waits in the queue for the next boundary. A reduced duty value therefore cannot land while the counter is already past it and leave a whole period stuck high.

Status reports the queue fill level, a flag for two or more queued words, and a sticky flag for writes lost to a full queue. Software also has an enable bit and a self-clearing soft-reset bit.

Top module: `dutyq_pwm`

## Requirements
- R1: With terminal value P in the PERIOD register (address 3), the counter steps 0,1,...,P and returns to 0, so a period lasts P+1 clocks. Reading the COUNT register (address 4) returns the counter value during the cycle in which the read is sampled.
- R2: With active sample D, the output is high for counts below D and low from count D to P. D = 0 gives a constant low output. D >= P gives a constant high output, so the period has P+1 high clocks.
- R3: The queue holds at most 4 samples. A write to DUTY (address 2) while 4 are queued is discarded and sets the overflow flag (STATUS bit 8). The flag stays set until a soft reset.
- R4: Samples leave the queue in write order, one at each period boundary. If the queue is empty at a boundary, the previous active sample is kept for the new period.
- R5: A DUTY write never changes the output within the current period, including a write into an empty queue. It first affects the period that follows the next boundary.
- R6: STATUS (address 1) bits [2:0] hold the number of queued samples. Bit 4 is set exactly when that number is at least 2.
- R7: CTRL (address 0) bit 0 enables the block. While disabled, the output is low and the counter is 0. The write that enables the block starts a period at count 0 and takes a queued sample for it, if one is available.
- R8: Writing 1 to CTRL bit 1 empties the queue and clears the overflow flag, the active sample, the counter and the enable bit, all in the same cycle. The PERIOD register keeps its value.
- R9: After reset, the output is low, STATUS reads 0, COUNT reads 0 and the active sample is 0.
- R10: A read strobe returns data on bus_rdata from the next clock on. DUTY reads back the active sample, not the queue. PERIOD reads back the programmed terminal value, which is 9 after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 3 | Register select (0 CTRL, 1 STATUS, 2 DUTY, 3 PERIOD, 4 COUNT) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |
| pwm_o | output | 1 | Modulated output, registered |

## Verification
A corrupted queue pointer or fill count shows as a wrong high-time within one period of the wrong entry becoming active. The bench captures whole periods and compares the high count of each one, so such a fault is caught in the first affected period. An active sample that changes at the wrong moment shows as a partial period whose high count matches neither the old duty nor the new one. A counter that wraps at the wrong value shifts every later period boundary. A COUNT readback taken at a known cycle offset exposes this within a dozen clocks.

// File: rtl/dutyq_pkg.sv
package dutyq_pkg;
  typedef enum logic [2:0] {
    RG_CTRL   = 3'd0,
    RG_STAT   = 3'd1,
    RG_DUTY   = 3'd2,
    RG_PERIOD = 3'd3,
    RG_COUNT  = 3'd4
  } reg_sel_e;

  localparam int unsigned CT_EN_BIT   = 0;
  localparam int unsigned CT_SRST_BIT = 1;
  localparam int unsigned ST_PAIR_BIT = 4;
  localparam int unsigned ST_OVF_BIT  = 8;
endpackage

// File: rtl/dutyq_fifo.sv
module dutyq_fifo #(
  parameter int DW    = 16,
  parameter int DEPTH = 4,
  localparam int FW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          push,
  input  logic [DW-1:0] wdata,
  input  logic          pop,
  output logic [DW-1:0] rdata,
  output logic [FW-1:0] fill,
  output logic          full,
  output logic          empty
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wp_q, rp_q;
  logic [FW-1:0] fill_q;
  logic          do_push, do_pop;

  assign full    = (fill_q == FW'(DEPTH));
  assign empty   = (fill_q == '0);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign rdata   = mem[rp_q];
  assign fill    = fill_q;

  // storage without reset so it maps to distributed RAM
  always_ff @(posedge clk) begin
    if (do_push) mem[wp_q] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      wp_q   <= '0;
      rp_q   <= '0;
      fill_q <= '0;
    end else begin
      if (do_push) wp_q <= (wp_q == AW'(DEPTH - 1)) ? '0 : wp_q + 1'b1;
      if (do_pop)  rp_q <= (rp_q == AW'(DEPTH - 1)) ? '0 : rp_q + 1'b1;
      case ({do_push, do_pop})
        2'b10:   fill_q <= fill_q + 1'b1;
        2'b01:   fill_q <= fill_q - 1'b1;
        default: fill_q <= fill_q;
      endcase
    end
  end

  assert_fill_bound_R3: assert property (@(posedge clk) disable iff (rst)
    fill_q <= FW'(DEPTH));

  assert_full_drop_R3: assert property (@(posedge clk) disable iff (rst)
    (push && full && !pop && !clr) |=> (fill_q == FW'(DEPTH)));
endmodule

// File: rtl/dutyq_core.sv
module dutyq_core #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          run_req,
  input  logic [CW-1:0] period,
  input  logic          q_empty,
  input  logic [CW-1:0] q_head,
  output logic          q_pop,
  output logic [CW-1:0] cnt,
  output logic [CW-1:0] act,
  output logic          pwm
);
  logic          run_q, pwm_q;
  logic [CW-1:0] cnt_q, act_q;
  logic          start, roll, load;
  logic [CW-1:0] cnt_d, act_d;
  logic          pwm_d;

  always_comb begin
    start = run_req && !run_q;
    roll  = run_q && run_req && (cnt_q >= period);
    load  = start || roll;
    q_pop = load && !q_empty;
    act_d = clr ? '0 : (q_pop ? q_head : act_q);
    cnt_d = (!run_req || load) ? '0 : cnt_q + 1'b1;
    pwm_d = run_req && (act_d != '0) && ((act_d >= period) || (cnt_d < act_d));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q <= 1'b0;
      cnt_q <= '0;
      act_q <= '0;
      pwm_q <= 1'b0;
    end else begin
      run_q <= run_req;
      cnt_q <= cnt_d;
      act_q <= act_d;
      pwm_q <= pwm_d;
    end
  end

  assign cnt = cnt_q;
  assign act = act_q;
  assign pwm = pwm_q;

  assert_hold_mid_R5: assert property (@(posedge clk) disable iff (rst)
    (act_q != $past(act_q)) |-> $past(load || clr));

  assert_wrap_R1: assert property (@(posedge clk) disable iff (rst)
    (run_q && cnt_q >= period) |=> (cnt_q == '0));

  assert_idle_R7: assert property (@(posedge clk) disable iff (rst)
    !run_q |-> (cnt_q == '0 && !pwm_q));

  assert_zero_low_R2: assert property (@(posedge clk) disable iff (rst)
    (run_q && act_q == '0) |-> !pwm_q);
endmodule

// File: rtl/dutyq_pwm.sv
module dutyq_pwm
  import dutyq_pkg::*;
#(
  parameter int CW         = 16,
  parameter int DEPTH      = 4,
  parameter int BW         = 32,
  parameter int PERIOD_RST = 9
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          bus_wr,
  input  logic          bus_rd,
  input  logic [2:0]    bus_addr,
  input  logic [BW-1:0] bus_wdata,
  output logic [BW-1:0] bus_rdata,
  output logic          pwm_o
);
  localparam int FW = $clog2(DEPTH + 1);

  logic          wr_ctrl, srst, push;
  logic          en_q, en_d, ovf_q;
  logic [CW-1:0] period_q;
  logic [FW-1:0] fill;
  logic          q_full, q_empty, q_pop;
  logic [CW-1:0] q_head, cnt, act;
  logic [BW-1:0] stat_w, rdata_q;
  logic          unused_hi;

  assign unused_hi = ^bus_wdata[BW-1:CW];

  assign wr_ctrl = bus_wr && (bus_addr == RG_CTRL);
  assign srst    = wr_ctrl && bus_wdata[CT_SRST_BIT];
  assign push    = bus_wr && (bus_addr == RG_DUTY);
  assign en_d    = srst ? 1'b0 : (wr_ctrl ? bus_wdata[CT_EN_BIT] : en_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q     <= 1'b0;
      ovf_q    <= 1'b0;
      period_q <= CW'(PERIOD_RST);
    end else begin
      en_q  <= en_d;
      ovf_q <= srst ? 1'b0 : (ovf_q || (push && q_full));
      if (bus_wr && bus_addr == RG_PERIOD) period_q <= bus_wdata[CW-1:0];
    end
  end

  always_comb begin
    stat_w              = '0;
    stat_w[FW-1:0]      = fill;
    stat_w[ST_PAIR_BIT] = (fill >= FW'(2));
    stat_w[ST_OVF_BIT]  = ovf_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q <= '0;
    end else if (bus_rd) begin
      case (bus_addr)
        RG_CTRL:   rdata_q <= BW'(en_q);
        RG_STAT:   rdata_q <= stat_w;
        RG_DUTY:   rdata_q <= BW'(act);
        RG_PERIOD: rdata_q <= BW'(period_q);
        RG_COUNT:  rdata_q <= BW'(cnt);
        default:   rdata_q <= '0;
      endcase
    end
  end
  assign bus_rdata = rdata_q;

  dutyq_fifo #(.DW(CW), .DEPTH(DEPTH)) u_fifo (
    .clk   (clk),
    .rst   (rst),
    .clr   (srst),
    .push  (push),
    .wdata (bus_wdata[CW-1:0]),
    .pop   (q_pop),
    .rdata (q_head),
    .fill  (fill),
    .full  (q_full),
    .empty (q_empty)
  );

  dutyq_core #(.CW(CW)) u_core (
    .clk     (clk),
    .rst     (rst),
    .clr     (srst),
    .run_req (en_d),
    .period  (period_q),
    .q_empty (q_empty),
    .q_head  (q_head),
    .q_pop   (q_pop),
    .cnt     (cnt),
    .act     (act),
    .pwm     (pwm_o)
  );

  assert_sticky_ovf_R3: assert property (@(posedge clk) disable iff (rst)
    ($past(ovf_q) && !$past(srst)) |-> ovf_q);

  assert_soft_clear_R8: assert property (@(posedge clk) disable iff (rst)
    $past(srst) |-> (fill == '0 && !ovf_q && !en_q && act == '0));
endmodule

// File: tb/dutyq_pwm_bench.sv
`timescale 1ns/1ps
module dutyq_pwm_bench;
  import dutyq_pkg::*;

  localparam int CW = 16, DEPTH = 4, BW = 32, PRST = 9;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          bus_wr = 1'b0, bus_rd = 1'b0;
  logic [2:0]    bus_addr = '0;
  logic [BW-1:0] bus_wdata = '0;
  logic [BW-1:0] bus_rdata;
  logic          pwm_o;

  int total = 0, bad = 0;
  int per = PRST;
  int hi[8];

  always #2 clk = ~clk;

  dutyq_pwm #(.CW(CW), .DEPTH(DEPTH), .BW(BW), .PERIOD_RST(PRST)) u_dutyq_pwm (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pwm_o(pwm_o)
  );

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic bus_write(input logic [2:0] a, input int d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1;
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [2:0] a, output int d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    @(posedge clk); #1;
    bus_rd = 1'b0;
    @(negedge clk);
    d = bus_rdata;
  endtask

  // call directly after the enabling write; cycle 0 is count 0
  task automatic capture(input int nper, input int wr_at, input int wr_val);
    for (int k = 0; k < 8; k++) hi[k] = 0;
    for (int i = 0; i < nper * (per + 1); i++) begin
      @(negedge clk);
      if (pwm_o) hi[i / (per + 1)]++;
      if (i == wr_at) begin
        bus_wr = 1'b1; bus_addr = RG_DUTY; bus_wdata = wr_val;
        @(posedge clk); #1;
        bus_wr = 1'b0;
      end
    end
  endtask

  function automatic int exp_hi(input int d);
    if (d == 0) return 0;
    if (d >= per) return per + 1;
    return d;
  endfunction

  task automatic t_reset();
    int d;
    @(negedge clk);
    chk("R9", "pwm after reset", pwm_o, 0);
    bus_read(RG_STAT, d);   chk("R9", "status after reset", d, 0);
    bus_read(RG_COUNT, d);  chk("R9", "count after reset", d, 0);
    bus_read(RG_DUTY, d);   chk("R10", "active duty after reset", d, 0);
    bus_read(RG_PERIOD, d); chk("R10", "period after reset", d, PRST);
  endtask

  task automatic t_duty_shapes();
    int duties[4] = '{4, 0, 9, 12};
    foreach (duties[n]) begin
      bus_write(RG_CTRL, 0);
      bus_write(RG_DUTY, duties[n]);
      bus_write(RG_CTRL, 1);
      capture(2, -1, 0);
      chk("R2", $sformatf("high clocks duty=%0d", duties[n]), hi[0], exp_hi(duties[n]));
      chk("R4", $sformatf("reuse duty=%0d", duties[n]), hi[1], exp_hi(duties[n]));
    end
  endtask

  task automatic t_fifo_order();
    int d;
    int exp_seq[5] = '{2, 5, 7, 3, 3};
    bus_write(RG_CTRL, 0);
    bus_write(RG_CTRL, 2);
    bus_write(RG_DUTY, 2);
    bus_read(RG_STAT, d); chk("R6", "status one word", d, 'h001);
    bus_write(RG_DUTY, 5);
    bus_read(RG_STAT, d); chk("R6", "status two words", d, 'h012);
    bus_write(RG_DUTY, 7);
    bus_write(RG_DUTY, 3);
    bus_read(RG_STAT, d); chk("R6", "status full", d, 'h014);
    bus_write(RG_DUTY, 8);
    bus_read(RG_STAT, d); chk("R3", "status after overflow", d, 'h114);
    bus_write(RG_CTRL, 1);
    capture(5, -1, 0);
    foreach (exp_seq[n]) chk("R4", $sformatf("period %0d order", n), hi[n], exp_seq[n]);
    bus_read(RG_STAT, d); chk("R3", "overflow sticky, queue drained", d, 'h100);
  endtask

  task automatic t_deferred();
    bus_write(RG_CTRL, 0);
    bus_write(RG_CTRL, 2);
    bus_write(RG_DUTY, 8);
    bus_write(RG_CTRL, 1);
    capture(3, 5, 3);
    chk("R5", "smaller write mid-period, current", hi[0], 8);
    chk("R5", "smaller write mid-period, next", hi[1], 3);
    chk("R4", "deferred value reused", hi[2], 3);
    bus_write(RG_CTRL, 0);
    bus_write(RG_DUTY, 2);
    bus_write(RG_CTRL, 1);
    capture(2, 6, 7);
    chk("R5", "larger write mid-period, current", hi[0], 2);
    chk("R5", "larger write mid-period, next", hi[1], 7);
  endtask

  task automatic t_counter();
    int d;
    bus_read(RG_PERIOD, d); chk("R10", "period readback", d, per);
    bus_write(RG_CTRL, 0);
    bus_write(RG_CTRL, 1);
    repeat (13) @(negedge clk);
    bus_rd = 1'b1; bus_addr = RG_COUNT;
    @(posedge clk); #1;
    @(negedge clk);
    chk("R1", "count at cycle 12", bus_rdata, 2);
    @(posedge clk); #1;
    bus_rd = 1'b0;
    @(negedge clk);
    chk("R1", "count at cycle 13", bus_rdata, 3);
  endtask

  task automatic t_disable();
    int d, h;
    bus_write(RG_DUTY, 6);
    bus_write(RG_CTRL, 1);
    repeat (15) @(negedge clk);
    bus_write(RG_CTRL, 0);
    h = 0;
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      if (pwm_o) h++;
    end
    chk("R7", "high clocks while disabled", h, 0);
    bus_read(RG_COUNT, d); chk("R7", "count while disabled", d, 0);
  endtask

  task automatic t_softreset();
    int d;
    for (int i = 0; i < 5; i++) bus_write(RG_DUTY, 4 + i);
    bus_write(RG_CTRL, 1);
    repeat (3) @(negedge clk);
    bus_write(RG_CTRL, 3);
    @(negedge clk);
    chk("R8", "pwm after soft reset", pwm_o, 0);
    bus_read(RG_STAT, d);   chk("R8", "status after soft reset", d, 0);
    bus_read(RG_DUTY, d);   chk("R8", "active duty after soft reset", d, 0);
    bus_read(RG_CTRL, d);   chk("R8", "enable after soft reset", d, 0);
    bus_read(RG_COUNT, d);  chk("R8", "count after soft reset", d, 0);
    bus_read(RG_PERIOD, d); chk("R8", "period kept", d, per);
  endtask

  initial begin
    #800000;
    bad++; total++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (4) @(posedge clk);
    #1 rst = 1'b0;
    t_reset();
    t_duty_shapes();
    t_fifo_order();
    t_deferred();
    t_counter();
    t_disable();
    t_softreset();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule